// File: doc/BRIEF.md
# Interrupt Cycle Sequencer

This block sits beside the instruction sequencer of a small accumulator-style processor. At the end of each instruction it decides whether the next cycle should be an interrupt cycle instead of an ordinary fetch. The decision uses the interrupt enable and the ready flags of the input and output devices. When it enters an interrupt cycle, the block carries out a branch that also saves the return address. It writes the current program counter to a fixed save location and then forces the program counter to a fixed resume location. The resume location is expected to hold a jump to the service routine. A service routine gets back to the interrupted program with an indirect branch through the save location.

The block owns two state bits: the interrupt enable and the pending flag. While the pending flag is high, the host sequencer must stay off its own fetch. The interrupt cycle takes three clock cycles: save, jump, clear. In the last of these, both the enable and the pending flag are dropped. Further interrupts stay masked until software turns the enable back on.

Top module: `irq_cycle_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ien` and `irq_pend` are 0 and neither `mem_we` nor `pc_load` is asserted.
- R2: `irq_pend` goes to 1 on the clock edge that samples `boundary`=1, `ien`=1 and at least one of `in_flag`/`out_flag` = 1.
- R3: `irq_pend` stays 0 if, at that edge, `boundary` is 0, `ien` is 0, or both device flags are 0.
- R4: In the first cycle with `irq_pend` high (save step), `mem_we`=1, `mem_addr`=SAVE_ADDR (default 0), and `mem_wdata` equals `pc_cur` in that same cycle.
- R5: In the second cycle (jump step), `pc_load`=1, `pc_value`=RESUME_ADDR (default 1), and `mem_we`=0.
- R6: In the third cycle (clear step), neither strobe is asserted. On the edge that ends it, both `irq_pend` and `ien` drop to 0, so `irq_pend` stays high for exactly three cycles.
- R7: After an interrupt cycle, no new one begins while `ien` is 0, even if a device flag and `boundary` stay high.
- R8: Outside an interrupt cycle, `ien_on` sets `ien` and `ien_off` clears it on the next edge. If both are high, `ien_off` wins.
- R9: While `irq_pend` is high, `ien_on`, `ien_off` and `boundary` have no effect on `ien` or on the step sequence.
- R10: `mem_we` and `pc_load` are never high together, and neither is ever high while `irq_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Last cycle of the current instruction |
| ien_on | input | 1 | Software request to enable interrupts |
| ien_off | input | 1 | Software request to disable interrupts |
| in_flag | input | 1 | Input device has a character ready |
| out_flag | input | 1 | Output device is ready to accept a character |
| pc_cur | input | AW | Current program counter (return address) |
| mem_we | output | 1 | Memory write request carrying the return address |
| mem_addr | output | AW | Write address (save location) |
| mem_wdata | output | AW | Write data (return address) |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | AW | Value to load (resume location) |
| ien | output | 1 | Interrupt enable state |
| irq_pend | output | 1 | Interrupt cycle in progress; the host suppresses its fetch |

## Verification
The assertions are evaluated on every cycle. They cover when the pending flag may and may not rise, the fixed order save → jump → clear with the enable dropping at the end, the fact that the enable cannot change in the middle of a sequence, and the rule that the strobes are exclusive and occur only during a sequence. Some properties depend on values across whole scenarios, and only the bench's scenarios can show them. These include the return address matching the program counter presented during the save step, the enable staying off across many boundaries with flags held high after an interrupt, the priority of disable over enable, and the reset behaviour in the middle of a sequence.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SAVE  = 2'd1,
        ST_JUMP  = 2'd2,
        ST_CLEAR = 2'd3
    } irq_step_e;

    typedef struct packed {
        logic mem_we;
        logic pc_load;
        logic seq_done;
    } irq_ctl_s;

    function automatic irq_step_e next_step(input irq_step_e s);
        case (s)
            ST_SAVE:  return ST_JUMP;
            ST_JUMP:  return ST_CLEAR;
            default:  return ST_IDLE;
        endcase
    endfunction

    function automatic irq_ctl_s decode_step(input irq_step_e s);
        irq_ctl_s c;
        c.mem_we   = (s == ST_SAVE);
        c.pc_load  = (s == ST_JUMP);
        c.seq_done = (s == ST_CLEAR);
        return c;
    endfunction

    function automatic logic want_irq(input logic at_end, input logic en,
                                      input logic fin, input logic fout);
        return at_end & en & (fin | fout);
    endfunction

endpackage

// File: rtl/irq_flag_detect.sv
`timescale 1ns/1ps
module irq_flag_detect
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic ien,
    input  logic in_flag,
    input  logic out_flag,
    input  logic seq_done,
    output logic pend,
    output logic take
);
    assign take = !pend && want_irq(boundary, ien, in_flag, out_flag);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (seq_done)
            pend <= 1'b0;
        else if (take)
            pend <= 1'b1;
    end
endmodule

// File: rtl/irq_step_fsm.sv
`timescale 1ns/1ps
module irq_step_fsm
    import irq_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    output irq_ctl_s  ctl
);
    irq_step_e step_q;

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= ST_IDLE;
        else if (step_q == ST_IDLE)
            step_q <= take ? ST_SAVE : ST_IDLE;
        else
            step_q <= next_step(step_q);
    end

    assign ctl = decode_step(step_q);
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    input  logic busy,
    input  logic seq_done,
    output logic ien
);
    always_ff @(posedge clk) begin
        if (rst)
            ien <= 1'b0;
        else if (seq_done)
            ien <= 1'b0;
        else if (!busy) begin
            if (clr_req)
                ien <= 1'b0;
            else if (set_req)
                ien <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_cycle_seq.sv
`timescale 1ns/1ps
module irq_cycle_seq
    import irq_seq_pkg::*;
#(
    parameter int AW          = 12,
    parameter int SAVE_ADDR   = 0,
    parameter int RESUME_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  logic          ien_on,
    input  logic          ien_off,
    input  logic          in_flag,
    input  logic          out_flag,
    input  logic [AW-1:0] pc_cur,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic          pc_load,
    output logic [AW-1:0] pc_value,
    output logic          ien,
    output logic          irq_pend
);
    localparam logic [AW-1:0] SAVE_VEC   = AW'(SAVE_ADDR);
    localparam logic [AW-1:0] RESUME_VEC = AW'(RESUME_ADDR);

    irq_ctl_s ctl;
    logic     take;

    irq_flag_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .ien      (ien),
        .in_flag  (in_flag),
        .out_flag (out_flag),
        .seq_done (ctl.seq_done),
        .pend     (irq_pend),
        .take     (take)
    );

    irq_step_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .ctl  (ctl)
    );

    irq_enable_reg u_ien (
        .clk      (clk),
        .rst      (rst),
        .set_req  (ien_on),
        .clr_req  (ien_off),
        .busy     (irq_pend),
        .seq_done (ctl.seq_done),
        .ien      (ien)
    );

    assign mem_we    = ctl.mem_we;
    assign mem_addr  = SAVE_VEC;
    assign mem_wdata = ctl.mem_we ? pc_cur : '0;
    assign pc_load   = ctl.pc_load;
    assign pc_value  = RESUME_VEC;
endmodule

// File: rtl/irq_cycle_chk.sv
`timescale 1ns/1ps
module irq_cycle_chk #(
    parameter int AW          = 12,
    parameter int SAVE_ADDR   = 0,
    parameter int RESUME_ADDR = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          boundary,
    input logic          in_flag,
    input logic          out_flag,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          pc_load,
    input logic [AW-1:0] pc_value,
    input logic          ien,
    input logic          irq_pend
);
    // R2
    a_r2_pend_rises: assert property (@(posedge clk) disable iff (rst)
        (!irq_pend && boundary && ien && (in_flag || out_flag)) |=> irq_pend);

    // R3
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!irq_pend && !(boundary && ien && (in_flag || out_flag))) |=> !irq_pend);

    // R4
    a_r4_save_first: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> (mem_we && mem_addr == AW'(SAVE_ADDR)));

    // R5
    a_r5_jump_follows: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (pc_load && !mem_we && pc_value == AW'(RESUME_ADDR)));

    // R6
    a_r6_clear_ends: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (irq_pend && !mem_we && !pc_load) ##1 (!irq_pend && !ien));

    // R7
    a_r7_masked: assert property (@(posedge clk) disable iff (rst)
        !ien |=> !$rose(irq_pend));

    // R9
    a_r9_ien_hold_save: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(ien));
    a_r9_ien_hold_jump: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> $stable(ien));

    // R10
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && pc_load));
    a_r10_only_pending: assert property (@(posedge clk) disable iff (rst)
        (mem_we || pc_load) |-> irq_pend);
endmodule

bind irq_cycle_seq irq_cycle_chk #(
    .AW          (AW),
    .SAVE_ADDR   (SAVE_ADDR),
    .RESUME_ADDR (RESUME_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .in_flag  (in_flag),
    .out_flag (out_flag),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .pc_load  (pc_load),
    .pc_value (pc_value),
    .ien      (ien),
    .irq_pend (irq_pend)
);

// File: tb/sim_irq_cycle_seq.sv
`timescale 1ns/1ps
module sim_irq_cycle_seq;
    localparam int AW = 12;
    localparam int CYC = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boundary = 1'b0, ien_on = 1'b0, ien_off = 1'b0;
    logic          in_flag = 1'b0, out_flag = 1'b0;
    logic [AW-1:0] pc_cur = '0;
    logic          mem_we, pc_load, ien, irq_pend;
    logic [AW-1:0] mem_addr, mem_wdata, pc_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit m_ien  = 0;
    bit m_pend = 0;
    int m_step = 0;   // 0 idle, 1 save, 2 jump, 3 clear

    always #(CYC/2) clk = ~clk;

    irq_cycle_seq #(.AW(AW), .SAVE_ADDR(0), .RESUME_ADDR(1)) u0 (
        .clk(clk), .rst(rst), .boundary(boundary), .ien_on(ien_on),
        .ien_off(ien_off), .in_flag(in_flag), .out_flag(out_flag),
        .pc_cur(pc_cur), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value),
        .ien(ien), .irq_pend(irq_pend)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(bit b, bit en, bit fi, bit fo, bit p);
        return !p && b && en && (fi || fo);
    endfunction

    // drive at negedge, check model against outputs, advance model across posedge
    task automatic cyc(input bit b, input bit on, input bit off,
                       input bit fi, input bit fo, input logic [AW-1:0] pc);
        bit t;
        @(negedge clk);
        boundary = b; ien_on = on; ien_off = off;
        in_flag = fi; out_flag = fo; pc_cur = pc;
        #2;
        chk(irq_pend == m_pend, "R2 R3 R7 irq_pend", irq_pend, m_pend);
        chk(ien == m_ien, "R8 R9 ien", ien, m_ien);
        chk(mem_we == (m_step == 1), "R4 R10 mem_we", mem_we, m_step == 1);
        chk(pc_load == (m_step == 2), "R5 R10 pc_load", pc_load, m_step == 2);
        if (m_step == 1) begin
            chk(mem_addr == 0, "R4 mem_addr", mem_addr, 0);
            chk(mem_wdata == pc, "R4 mem_wdata", mem_wdata, pc);
        end
        if (m_step == 2)
            chk(pc_value == 1, "R5 pc_value", pc_value, 1);
        if (m_pend) begin
            if (m_step == 3) begin
                m_pend = 0; m_ien = 0; m_step = 0;
            end else
                m_step++;
        end else begin
            t = exp_take(b, m_ien, fi, fo, m_pend);
            if (t) begin m_pend = 1; m_step = 1; end
            if (off) m_ien = 0;
            else if (on) m_ien = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        boundary = 0; ien_on = 0; ien_off = 0; in_flag = 0; out_flag = 0;
        @(posedge clk); #2;
        chk(ien == 0 && irq_pend == 0, "R1 state in reset", {ien, irq_pend}, 0);
        chk(!mem_we && !pc_load, "R1 strobes in reset", {mem_we, pc_load}, 0);
        @(negedge clk);
        rst = 1'b0;
        m_ien = 0; m_pend = 0; m_step = 0;
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int pend_len;
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: first cycle after reset
        cyc(1, 0, 0, 1, 1, 12'h123);
        chk(irq_pend == 0, "R1 no pend after reset", irq_pend, 0);

        // R3: enable off, flags high, boundary high
        cyc(1, 0, 0, 1, 1, 12'h100);
        // R8: enable
        cyc(0, 1, 0, 0, 0, 12'h100);
        chk(m_ien == 1, "R8 model enable", m_ien, 1);
        // R3: boundary low, flags high
        cyc(0, 0, 0, 1, 1, 12'h101);
        // R3: boundary high, flags low
        cyc(1, 0, 0, 0, 0, 12'h102);
        // R2: input flag only
        cyc(1, 0, 0, 1, 0, 12'h2A5);
        // R4/R5/R6 plus R9: requests and boundary during sequence
        pend_len = 0;
        for (int i = 0; i < 3; i++) begin
            #0;
            cyc(1, i == 0, i == 1, 1, 1, 12'h2A5);
            if (irq_pend) pend_len++;
        end
        chk(pend_len == 3, "R6 pend length", pend_len, 3);
        cyc(0, 0, 0, 0, 0, 12'h2A6);
        chk(ien == 0 && irq_pend == 0, "R6 cleared after clear step", {ien, irq_pend}, 0);
        // R7: flags stay high with enable off
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 1, 1, 12'h300);
        chk(irq_pend == 0, "R7 stays masked", irq_pend, 0);
        // R8: both requests -> off wins
        cyc(0, 1, 0, 0, 0, 12'h300);
        cyc(0, 1, 1, 0, 0, 12'h300);
        cyc(0, 0, 0, 0, 0, 12'h300);
        chk(ien == 0, "R8 off wins", ien, 0);
        // R2: output flag only
        cyc(0, 1, 0, 0, 0, 12'hFFF);
        cyc(1, 0, 0, 0, 1, 12'hFFF);
        cyc(0, 0, 0, 0, 0, 12'hFFF);
        // R1: reset mid-sequence
        do_reset();
        cyc(0, 0, 0, 0, 0, 12'h000);
        chk(!mem_we && !pc_load && !irq_pend, "R1 reset mid-sequence", {mem_we, pc_load, irq_pend}, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 3) == 0, ($urandom % 6) == 0, ($urandom % 10) == 0,
                ($urandom % 4) == 0, ($urandom % 5) == 0, AW'($urandom));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule